// File: doc/BRIEF.md
# SDRAM Row/Column Address Multiplexer

This block turns a flat 30-bit system byte address into the two halves that an SDRAM device expects. When a row strobe arrives, it registers a row address and a bank number. When a column strobe arrives, it registers a column address. Which system bits feed the bank lines, the row and the column depends on a 3-bit decode setting. A 2-bit density setting selects how many device lines are live.

Each output line has its own output-enable bit. This models a line that floats when the attached device density does not use it. The bank number captured in the row phase is kept and is driven again in the column phase. In the column phase, device address bit 10 carries the auto-precharge request, and this block always drives it to 0. An illegal combination of decode setting and density raises an error flag and zeroes every address and bank line.

Top module: `sdram_addr_mux`

## Requirements
- R1: A cycle with `row_stb` high updates the outputs at that clock edge. `dev_addr[12:0]` then gets, per setting (bit 12 first): 001 and 010 give sys[25:13]; 011 gives sys[25:15],sys[12:11]; 100 gives sys[25:23],sys[20:11]; 101 gives sys[25],sys[22:11]; 110 gives sys[23:11]; 111 gives sys[27],sys[22:11]. `dev_bank[0]`/`dev_bank[1]` get sys bit pairs 6/7, 11/12, 13/14, 21/22, 23/24, 24/25 and 25/26 for settings 001 to 111.
- R2: A cycle with only `col_stb` high drives `dev_addr` as follows: bit 12 = sys[29] and bit 11 = sys[28]. Bits 9:8 = sys[27:26], except setting 111 which uses sys[24:23]. Bits 7:0 = sys[10:3], except setting 001 which uses sys[12:8],sys[5:3].
- R3: In every column phase, `dev_addr[10]` is 0.
- R4: The column-phase `dev_bank` equals the bank captured at the most recent row phase. The system address presented at column time has no effect on it.
- R5: The density code sets the live lines, and every line that is not live reads 0. Code 00 (16 Mbit) enables address 10:0 and bank 0. Code 01 (64/128 Mbit) enables address 11:0 and both bank lines. Code 10 (256 Mbit) enables address 12:0 and both bank lines. Code 11 enables nothing.
- R6: With density 00 and setting 000, the row phase drives bank 0 from sys[13] and address 10:0 from sys[24:14]. The column phase drives address 9:0 from sys[12:3].
- R7: Setting 000 with density 01 or 10, or any setting with density 11, is illegal. A strobe under an illegal combination sets `cfg_err`, drives `dev_addr` and `dev_bank` to 0, and clears the captured bank. The next legal strobe clears `cfg_err`.
- R8: In a cycle with neither strobe, all outputs keep their values.
- R9: When both strobes are high together, the row phase is performed.
- R10: A synchronous active-low reset zeroes all outputs, all enables, `cfg_err` and the captured bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_addr | input | 30 | Flat system byte address |
| decode_sel | input | 3 | Bit-placement setting |
| density | input | 2 | Device density code |
| row_stb | input | 1 | Row-phase strobe |
| col_stb | input | 1 | Column-phase strobe |
| dev_addr | output | 13 | Multiplexed device address |
| dev_addr_oe | output | 13 | Per-line enable for dev_addr |
| dev_bank | output | 2 | Bank select |
| dev_bank_oe | output | 2 | Per-line enable for dev_bank |
| cfg_err | output | 1 | Illegal setting flag |

## Verification
The bench sweeps every density and setting pair with walking-one and random addresses, and checks each output bit against a per-bit source index. A swapped or shifted bit field therefore shows up as one wrong bit. A design that leaked a column bit into line 10, or that forgot to mask lines left floating in 16 Mbit mode, would show a nonzero bit where 0 is required. Between the phases the bench changes the system address. A design that took the column bank from live input instead of the captured value, or that kept a stale bank after an illegal row phase, is caught this way. The bench also checks the priority when both strobes are high, and the state right after reset.

// File: rtl/sdram_amux_pkg.sv
// Package: shared widths and the density code for the SDRAM address multiplexer.
// Assumes: the bit placement tables are fixed to a 30-bit system address,
// a 13-line device address and two bank lines.
package sdram_amux_pkg;
    localparam int SYS_AW = 30;
    localparam int DEV_AW = 13;
    localparam int BANK_W = 2;
    localparam int SEL_W  = 3;

    typedef enum logic [1:0] {
        DEN_16M  = 2'b00,
        DEN_64M  = 2'b01,
        DEN_256M = 2'b10,
        DEN_RSVD = 2'b11
    } density_e;
endpackage

// File: rtl/sdram_lane_ctl.sv
// Module: turns the density code into per-line enable masks and flags
// illegal setting/density combinations.
// Assumes: lane counts are at most DEV_AW and bank lanes at most BANK_W.
module sdram_lane_ctl
    import sdram_amux_pkg::*;
#(
    parameter int ADDR_W    = DEV_AW,
    parameter int BNK_W     = BANK_W,
    parameter int LANES_16M = 11,
    parameter int LANES_64M = 12,
    parameter int LANES_256 = 13
) (
    input  density_e           density,
    input  logic [SEL_W-1:0]   sel,
    output logic [ADDR_W-1:0]  addr_mask,
    output logic [BNK_W-1:0]   bank_mask,
    output logic               illegal
);
    int addr_lanes;
    int bank_lanes;

    // Purpose: number of live address and bank lines per density.
    always_comb begin
        case (density)
            DEN_16M:  begin addr_lanes = LANES_16M; bank_lanes = 1;     end
            DEN_64M:  begin addr_lanes = LANES_64M; bank_lanes = BNK_W; end
            DEN_256M: begin addr_lanes = LANES_256; bank_lanes = BNK_W; end
            default:  begin addr_lanes = 0;         bank_lanes = 0;     end
        endcase
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr_lane
        assign addr_mask[i] = (addr_lanes > i);
    end

    for (genvar j = 0; j < BNK_W; j++) begin : g_bank_lane
        assign bank_mask[j] = (bank_lanes > j);
    end

    // Purpose: setting 000 is only meaningful for the smallest density.
    always_comb begin
        illegal = (density == DEN_RSVD) ||
                  ((density != DEN_16M) && (sel == '0));
    end
endmodule

// File: rtl/sdram_row_map.sv
// Module: selects row address and bank bits from the system address
// for each decode setting.
// Assumes: setting 000 is the small-density placement; masking of unused
// lines happens in the caller.
module sdram_row_map
    import sdram_amux_pkg::*;
(
    input  logic [SYS_AW-1:0] sys_addr,
    input  logic [SEL_W-1:0]  sel,
    output logic [DEV_AW-1:0] row,
    output logic [BANK_W-1:0] bank
);
    // Purpose: row and bank bit placement per setting.
    always_comb begin
        case (sel)
            3'd0: begin
                row  = {2'b00, sys_addr[24:14]};
                bank = {1'b0, sys_addr[13]};
            end
            3'd1: begin
                row  = sys_addr[25:13];
                bank = {sys_addr[7], sys_addr[6]};
            end
            3'd2: begin
                row  = sys_addr[25:13];
                bank = {sys_addr[12], sys_addr[11]};
            end
            3'd3: begin
                row  = {sys_addr[25:15], sys_addr[12:11]};
                bank = {sys_addr[14], sys_addr[13]};
            end
            3'd4: begin
                row  = {sys_addr[25:23], sys_addr[20:11]};
                bank = {sys_addr[22], sys_addr[21]};
            end
            3'd5: begin
                row  = {sys_addr[25], sys_addr[22:11]};
                bank = {sys_addr[24], sys_addr[23]};
            end
            3'd6: begin
                row  = sys_addr[23:11];
                bank = {sys_addr[25], sys_addr[24]};
            end
            default: begin
                row  = {sys_addr[27], sys_addr[22:11]};
                bank = {sys_addr[26], sys_addr[25]};
            end
        endcase
    end
endmodule

// File: rtl/sdram_col_map.sv
// Module: selects column address bits per decode setting and keeps the
// auto-precharge line (bit 10) at zero.
// Assumes: masking of unused lines happens in the caller.
module sdram_col_map
    import sdram_amux_pkg::*;
(
    input  logic [SYS_AW-1:0] sys_addr,
    input  logic [SEL_W-1:0]  sel,
    output logic [DEV_AW-1:0] col
);
    logic [1:0] upper;
    logic [7:0] lower;

    // Purpose: pick the two upper column bits.
    always_comb begin
        if (sel == 3'd7) upper = sys_addr[24:23];
        else             upper = sys_addr[27:26];
    end

    // Purpose: pick the eight lower column bits.
    always_comb begin
        if (sel == 3'd1) lower = {sys_addr[12:8], sys_addr[5:3]};
        else             lower = sys_addr[10:3];
    end

    // Purpose: assemble the column word; setting 000 uses a plain 10-bit column.
    always_comb begin
        if (sel == 3'd0) col = {3'b000, sys_addr[12:3]};
        else             col = {sys_addr[29], sys_addr[28], 1'b0, upper, lower};
    end
endmodule

// File: rtl/sdram_bank_hold.sv
// Module: captures the bank number in the row phase for reuse in the
// column phase.
// Assumes: load_val is already masked to the live bank lines.
module sdram_bank_hold
    import sdram_amux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb,
    input  logic              illegal,
    input  logic [BANK_W-1:0] load_val,
    output logic [BANK_W-1:0] held
);
    // Purpose: load on row phase, clear on illegal row phase or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (row_stb) held <= illegal ? '0 : load_val;
    end

    p_bank_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (row_stb && illegal) |=> (held == '0));
endmodule

// File: rtl/sdram_addr_mux.sv
// Module: top of the SDRAM row/column address multiplexer. Registers the
// row or column word on the matching strobe, with per-line enables.
// Assumes: row strobe wins over column strobe; idle cycles hold all outputs.
module sdram_addr_mux
    import sdram_amux_pkg::*;
#(
    parameter int LANES_16M = 11,
    parameter int LANES_64M = 12,
    parameter int LANES_256 = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [29:0]       sys_addr,
    input  logic [2:0]        decode_sel,
    input  logic [1:0]        density,
    input  logic              row_stb,
    input  logic              col_stb,
    output logic [12:0]       dev_addr,
    output logic [12:0]       dev_addr_oe,
    output logic [1:0]        dev_bank,
    output logic [1:0]        dev_bank_oe,
    output logic              cfg_err
);
    logic [DEV_AW-1:0] addr_mask;
    logic [BANK_W-1:0] bank_mask;
    logic              illegal;
    logic [DEV_AW-1:0] row_raw;
    logic [BANK_W-1:0] bank_raw;
    logic [DEV_AW-1:0] col_raw;
    logic [BANK_W-1:0] bank_held;
    logic              col_only;

    sdram_lane_ctl #(
        .ADDR_W    (DEV_AW),
        .BNK_W     (BANK_W),
        .LANES_16M (LANES_16M),
        .LANES_64M (LANES_64M),
        .LANES_256 (LANES_256)
    ) u_lane (
        .density   (density_e'(density)),
        .sel       (decode_sel),
        .addr_mask (addr_mask),
        .bank_mask (bank_mask),
        .illegal   (illegal)
    );

    sdram_row_map u_row (
        .sys_addr (sys_addr),
        .sel      (decode_sel),
        .row      (row_raw),
        .bank     (bank_raw)
    );

    sdram_col_map u_col (
        .sys_addr (sys_addr),
        .sel      (decode_sel),
        .col      (col_raw)
    );

    sdram_bank_hold u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_stb  (row_stb),
        .illegal  (illegal),
        .load_val (bank_raw & bank_mask),
        .held     (bank_held)
    );

    // Purpose: column phase only when row strobe is absent.
    always_comb col_only = col_stb && !row_stb;

    // Purpose: output registers for address, bank, enables and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr    <= '0;
            dev_addr_oe <= '0;
            dev_bank    <= '0;
            dev_bank_oe <= '0;
            cfg_err     <= 1'b0;
        end else if (row_stb) begin
            dev_addr    <= illegal ? '0 : (row_raw & addr_mask);
            dev_bank    <= illegal ? '0 : (bank_raw & bank_mask);
            dev_addr_oe <= addr_mask;
            dev_bank_oe <= bank_mask;
            cfg_err     <= illegal;
        end else if (col_stb) begin
            dev_addr    <= illegal ? '0 : (col_raw & addr_mask);
            dev_bank    <= illegal ? '0 : (bank_held & bank_mask);
            dev_addr_oe <= addr_mask;
            dev_bank_oe <= bank_mask;
            cfg_err     <= illegal;
        end
    end

    p_precharge_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_only |=> (dev_addr[10] == 1'b0));

    p_bank_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_only && !illegal) |=> (dev_bank == ($past(bank_held) & dev_bank_oe)));

    p_float_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_addr & ~dev_addr_oe) == '0) && ((dev_bank & ~dev_bank_oe) == '0));

    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ((dev_addr == '0) && (dev_bank == '0)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_stb && !col_stb) |=> ($stable(dev_addr) && $stable(dev_bank) &&
                                    $stable(cfg_err) && $stable(dev_addr_oe)));
endmodule

// File: tb/sdram_addr_mux_tb.sv
module sdram_addr_mux_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [29:0] sys_addr;
    logic [2:0]  decode_sel;
    logic [1:0]  density;
    logic        row_stb, col_stb;
    logic [12:0] dev_addr, dev_addr_oe;
    logic [1:0]  dev_bank, dev_bank_oe;
    logic        cfg_err;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_addr_mux u_dut (
        .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .decode_sel(decode_sel),
        .density(density), .row_stb(row_stb), .col_stb(col_stb),
        .dev_addr(dev_addr), .dev_addr_oe(dev_addr_oe), .dev_bank(dev_bank),
        .dev_bank_oe(dev_bank_oe), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input int den, input int sel);
        return !(den == 3 || (den != 0 && sel == 0));
    endfunction

    function automatic int addr_lanes(input int den);
        case (den)
            0: return 11;
            1: return 12;
            2: return 13;
            default: return 0;
        endcase
    endfunction

    function automatic int bank_lanes(input int den);
        return (den == 0) ? 1 : ((den == 3) ? 0 : 2);
    endfunction

    function automatic int row_src(input int sel, input int pos);
        case (sel)
            0: return (pos <= 10) ? pos + 14 : -1;
            1, 2: return pos + 13;
            3: return (pos >= 2) ? pos + 13 : pos + 11;
            4: return (pos >= 10) ? pos + 13 : pos + 11;
            5: return (pos == 12) ? 25 : pos + 11;
            6: return pos + 11;
            default: return (pos == 12) ? 27 : pos + 11;
        endcase
    endfunction

    function automatic int bank_src(input int sel, input int b);
        int base;
        case (sel)
            0: base = 13;
            1: base = 6;
            2: base = 11;
            3: base = 13;
            4: base = 21;
            5: base = 23;
            6: base = 24;
            default: base = 25;
        endcase
        if (sel == 0 && b == 1) return -1;
        return base + b;
    endfunction

    function automatic int col_src(input int sel, input int pos);
        if (sel == 0) return (pos <= 9) ? pos + 3 : -1;
        if (pos == 12) return 29;
        if (pos == 11) return 28;
        if (pos == 10) return -1;
        if (pos == 9) return (sel == 7) ? 24 : 27;
        if (pos == 8) return (sel == 7) ? 23 : 26;
        if (sel == 1) return (pos < 3) ? pos + 3 : pos + 5;
        return pos + 3;
    endfunction

    function automatic logic [12:0] exp_addr(input bit is_col, input int den, input int sel,
                                             input logic [29:0] a);
        logic [12:0] r = '0;
        int s;
        if (!legal(den, sel)) return '0;
        for (int p = 0; p < 13; p++) begin
            s = is_col ? col_src(sel, p) : row_src(sel, p);
            if (s >= 0 && p < addr_lanes(den)) r[p] = a[s];
        end
        return r;
    endfunction

    function automatic logic [1:0] exp_bank(input int den, input int sel, input logic [29:0] a);
        logic [1:0] r = '0;
        int s;
        if (!legal(den, sel)) return '0;
        for (int b = 0; b < 2; b++) begin
            s = bank_src(sel, b);
            if (s >= 0 && b < bank_lanes(den)) r[b] = a[s];
        end
        return r;
    endfunction

    task automatic run_access(input int den, input int sel, input logic [29:0] ar,
                              input logic [29:0] ac);
        logic [12:0] er, ec, amask;
        logic [1:0]  eb, bmask;
        string rtag, ctag;
        er = exp_addr(0, den, sel, ar);
        ec = exp_addr(1, den, sel, ac);
        eb = exp_bank(den, sel, ar);
        amask = 13'((1 << addr_lanes(den)) - 1);
        bmask = 2'((1 << bank_lanes(den)) - 1);
        rtag = (!legal(den, sel)) ? "R7" : ((sel == 0) ? "R6" : "R1");
        ctag = (!legal(den, sel)) ? "R7" : ((sel == 0) ? "R6" : "R2");
        density = 2'(den); decode_sel = 3'(sel); sys_addr = ar;
        row_stb = 1'b1; col_stb = 1'b0;
        @(negedge clk);
        row_stb = 1'b0;
        chk({rtag, " row addr"}, 32'(dev_addr), 32'(er));
        chk({rtag, " row bank"}, 32'(dev_bank), 32'(eb));
        chk("R5 addr enable", 32'(dev_addr_oe), 32'(amask));
        chk("R5 bank enable", 32'(dev_bank_oe), 32'(bmask));
        chk("R7 error flag", 32'(cfg_err), 32'(!legal(den, sel)));
        sys_addr = ac; col_stb = 1'b1;
        @(negedge clk);
        col_stb = 1'b0;
        chk({ctag, " col addr"}, 32'(dev_addr), 32'(ec));
        chk("R3 precharge bit", 32'(dev_addr[10]), 32'(0));
        chk("R4 col bank", 32'(dev_bank), 32'(eb));
        sys_addr = ~ac; decode_sel = 3'(sel + 1);
        @(negedge clk);
        chk("R8 hold addr", 32'(dev_addr), 32'(ec));
        chk("R8 hold bank", 32'(dev_bank), 32'(eb));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; sys_addr = '1; decode_sel = 3'd2; density = 2'd1;
        row_stb = 1'b1; col_stb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset addr", 32'(dev_addr), 32'(0));
        chk("R10 reset enables", 32'({dev_addr_oe, dev_bank_oe}), 32'(0));
        chk("R10 reset bank/err", 32'({dev_bank, cfg_err}), 32'(0));
        row_stb = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", 32'({dev_addr, dev_bank, cfg_err}), 32'(0));
        // column without prior row: captured bank must be zero after reset
        col_stb = 1'b1;
        @(negedge clk);
        col_stb = 1'b0;
        chk("R10 cleared captured bank", 32'(dev_bank), 32'(0));
        chk("R10 col addr", 32'(dev_addr), 32'(exp_addr(1, 1, 2, '1)));

        // sweep all density/setting pairs
        for (int den = 0; den < 4; den++) begin
            for (int sel = 0; sel < 8; sel++) begin
                for (int k = 0; k < 30; k++) begin
                    run_access(den, sel, 30'(1) << k, ~(30'(1) << k));
                end
                for (int r = 0; r < 4; r++) begin
                    run_access(den, sel, 30'($urandom), 30'($urandom));
                end
            end
        end

        // R9: both strobes together perform the row phase
        density = 2'd2; decode_sel = 3'd3; sys_addr = 30'h2AAA_5555;
        row_stb = 1'b1; col_stb = 1'b1;
        @(negedge clk);
        row_stb = 1'b0; col_stb = 1'b0;
        chk("R9 row wins addr", 32'(dev_addr), 32'(exp_addr(0, 2, 3, 30'h2AAA_5555)));
        chk("R9 row wins bank", 32'(dev_bank), 32'(exp_bank(2, 3, 30'h2AAA_5555)));

        // R7: illegal row phase clears the captured bank
        density = 2'd1; decode_sel = 3'd2; sys_addr = '1; row_stb = 1'b1;
        @(negedge clk);
        chk("R7 pre bank", 32'(dev_bank), 32'(3));
        decode_sel = 3'd0;
        @(negedge clk);
        row_stb = 1'b0;
        chk("R7 illegal flag", 32'(cfg_err), 32'(1));
        decode_sel = 3'd2; col_stb = 1'b1;
        @(negedge clk);
        col_stb = 1'b0;
        chk("R7 bank cleared", 32'(dev_bank), 32'(0));
        chk("R7 flag cleared", 32'(cfg_err), 32'(0));

        summary();
    end
endmodule